// File: doc/BRIEF.md
# Floppy controller command sequencer

This block is the byte-wide host side of a floppy disk controller, covering the positioning commands only. The host reads an 8-bit status byte that shows when the controller will take a byte, which way the next byte travels, and whether a command is under way. Command bytes go in through a data write port and result bytes come back through a data read port. The block handles the absolute seek, the two relative seeks and the sense-interrupt command. It keeps the present cylinder of one drive.

A seek takes its bytes, then spends a fixed, parameterised number of cycles in execution. It then sets a pending interrupt, which the host clears by issuing sense-interrupt. Sense-interrupt returns a status byte and the present cylinder. With nothing pending, it returns a single invalid-command byte. An unknown opcode also gets that single byte and touches nothing else.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte reads 0x80 and the interrupt output is low.
- R2: Status bit 7 means a host byte may move, bit 6 set means the next byte goes from controller to host, bit 4 means a command is in progress, and bits 5 and 3:0 read 0. The status is 0x80 when idle, 0x90 while parameter bytes are awaited, 0x10 during seek execution and 0xD0 while results are waiting.
- R3: A data write is taken only while status shows bit 7 set and bit 6 clear. A write during execution or during the result phase changes neither the state nor the pending result bytes.
- R4: Opcode 0x0F is a three-byte absolute seek. The second byte holds the head in bit 2 and the drive in bits 1:0. The third byte is the target cylinder, limited to MAX_CYL.
- R5: Opcode 0x8F lowers the cylinder by the third byte and stops at 0. Opcode 0xCF raises it and stops at MAX_CYL.
- R6: Execution lasts exactly SEEK_CYCLES clock cycles, counted from the edge that takes the last seek byte. The interrupt rises, and the status returns to 0x80, on the edge SEEK_CYCLES cycles after that edge.
- R7: The interrupt stays low while seek bytes are being taken. Accepting a seek opcode clears an interrupt still pending from an earlier seek.
- R8: Opcode 0x08 with an interrupt pending returns two bytes. The first is 0x20 OR (head<<2) OR drive of the last seek, and the second is the present cylinder. The interrupt is low from the cycle after the opcode is taken.
- R9: Opcode 0x08 with no interrupt pending returns the single byte 0x80.
- R10: Any other opcode returns the single byte 0x80. It leaves the cylinder and any pending interrupt unchanged.
- R11: The status reads 0x80 on the cycle after the last result byte is read. A read strobe outside the result phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | One-cycle strobe writing `cmd_wdata` to the data port |
| cmd_wdata | input | 8 | Command or parameter byte |
| res_rd | input | 1 | One-cycle strobe consuming the current result byte |
| res_rdata | output | 8 | Result byte currently offered to the host |
| stat_o | output | 8 | Status byte |
| irq_o | output | 1 | Seek-complete interrupt |

## Verification
Status and the cleared interrupt are due one cycle after the edge that takes a byte. The bench checks them 1 ns after that edge. The interrupt of a seek is due SEEK_CYCLES edges after the last seek byte. A free-running edge counter records that edge, and the bench checks both the cycle just before (interrupt low, status 0x10) and the cycle itself (interrupt high, status 0x80). Result bytes are compared only while the read strobe is high and the status shows the result phase, so each byte is sampled before the edge that consumes it.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    localparam logic [7:0] OPC_SEEK_ABS = 8'h0F;
    localparam logic [7:0] OPC_SEEK_OUT = 8'h8F;
    localparam logic [7:0] OPC_SEEK_IN  = 8'hCF;
    localparam logic [7:0] OPC_SENSE    = 8'h08;

    localparam logic [7:0] ST0_SEEK_END = 8'h20;
    localparam logic [7:0] BYTE_INVALID = 8'h80;

    localparam int STB_RQM  = 7;
    localparam int STB_DIO  = 6;
    localparam int STB_BUSY = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PARAM,
        PH_EXEC,
        PH_RESULT
    } phase_e;

    typedef enum logic [2:0] {
        OP_ABS,
        OP_OUT,
        OP_IN,
        OP_SENSE,
        OP_BAD
    } op_kind_e;

endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode
    import fdc_seq_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind,
    output logic       is_seek
);

    always_comb begin
        unique case (opcode)
            OPC_SEEK_ABS: kind = OP_ABS;
            OPC_SEEK_OUT: kind = OP_OUT;
            OPC_SEEK_IN:  kind = OP_IN;
            OPC_SENSE:    kind = OP_SENSE;
            default:      kind = OP_BAD;
        endcase
        is_seek = (kind == OP_ABS) || (kind == OP_OUT) || (kind == OP_IN);
    end

endmodule

// File: rtl/fdc_cyl_step.sv
module fdc_cyl_step
    import fdc_seq_pkg::*;
#(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79
) (
    input  op_kind_e         kind,
    input  logic [CYL_W-1:0] cur,
    input  logic [7:0]       arg,
    output logic [CYL_W-1:0] nxt
);

    // Wide enough for cylinder or argument plus one carry bit
    localparam int SW = ((CYL_W > 8) ? CYL_W : 8) + 1;
    localparam logic [SW-1:0] LIM = SW'(MAX_CYL);

    logic [SW-1:0] cur_w;
    logic [SW-1:0] arg_w;
    logic [SW-1:0] raw;

    always_comb begin
        cur_w = SW'(cur);
        arg_w = SW'(arg);
        case (kind)
            OP_ABS:  raw = arg_w;
            OP_OUT:  raw = (cur_w > arg_w) ? (cur_w - arg_w) : '0;
            OP_IN:   raw = cur_w + arg_w;
            default: raw = cur_w;
        endcase
        nxt = CYL_W'((raw > LIM) ? LIM : raw);
    end

endmodule

// File: rtl/fdc_seek_timer.sv
module fdc_seek_timer #(
    parameter int SEEK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = (SEEK_CYCLES > 1) ? $clog2(SEEK_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SEEK_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.run;
    assign done = tmr_q.run && (tmr_q.cnt == '0);

    // R6
    timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tmr_q.run);

    // R6
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && !done) |=> tmr_q.run);

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int CYL_W       = 8,
    parameter int MAX_CYL     = 79,
    parameter int SEEK_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_wdata,
    input  logic       res_rd,
    output logic [7:0] res_rdata,
    output logic [7:0] stat_o,
    output logic       irq_o
);

    typedef struct packed {
        phase_e           phase;
        op_kind_e         kind;
        logic             need_sel;
        logic [2:0]       hd_drv;
        logic [7:0]       arg;
        logic [CYL_W-1:0] pcn;
        logic             pend;
        logic [7:0]       res0;
        logic [7:0]       res1;
        logic             two;
        logic             idx;
    } seq_t;

    seq_t seq_d, seq_q;

    op_kind_e         dec_kind;
    logic             dec_seek;
    logic [CYL_W-1:0] step_pcn;
    logic             tmr_start;
    logic             tmr_busy;
    logic             seek_done;

    fdc_op_decode u_dec (
        .opcode  (cmd_wdata),
        .kind    (dec_kind),
        .is_seek (dec_seek)
    );

    fdc_cyl_step #(
        .CYL_W   (CYL_W),
        .MAX_CYL (MAX_CYL)
    ) u_step (
        .kind (seq_q.kind),
        .cur  (seq_q.pcn),
        .arg  (seq_q.arg),
        .nxt  (step_pcn)
    );

    fdc_seek_timer #(
        .SEEK_CYCLES (SEEK_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (seek_done)
    );

    always_comb begin
        seq_d     = seq_q;
        tmr_start = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (cmd_wr) begin
                    seq_d.kind = dec_kind;
                    seq_d.idx  = 1'b0;
                    if (dec_seek) begin
                        seq_d.phase    = PH_PARAM;
                        seq_d.need_sel = 1'b1;
                        seq_d.pend     = 1'b0;
                    end else if (dec_kind == OP_SENSE && seq_q.pend) begin
                        seq_d.phase = PH_RESULT;
                        seq_d.res0  = ST0_SEEK_END | {5'b0, seq_q.hd_drv};
                        seq_d.res1  = 8'(seq_q.pcn);
                        seq_d.two   = 1'b1;
                        seq_d.pend  = 1'b0;
                    end else begin
                        seq_d.phase = PH_RESULT;
                        seq_d.res0  = BYTE_INVALID;
                        seq_d.two   = 1'b0;
                    end
                end
            end
            PH_PARAM: begin
                if (cmd_wr) begin
                    if (seq_q.need_sel) begin
                        seq_d.hd_drv   = cmd_wdata[2:0];
                        seq_d.need_sel = 1'b0;
                    end else begin
                        seq_d.arg   = cmd_wdata;
                        seq_d.phase = PH_EXEC;
                        tmr_start   = 1'b1;
                    end
                end
            end
            PH_EXEC: begin
                if (seek_done) begin
                    seq_d.pcn   = step_pcn;
                    seq_d.pend  = 1'b1;
                    seq_d.phase = PH_IDLE;
                end
            end
            default: begin
                if (res_rd) begin
                    if (seq_q.two && !seq_q.idx) begin
                        seq_d.idx = 1'b1;
                    end else begin
                        seq_d.idx   = 1'b0;
                        seq_d.phase = PH_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
            seq_q.kind  <= OP_BAD;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        stat_o = 8'h00;
        case (seq_q.phase)
            PH_IDLE: stat_o[STB_RQM] = 1'b1;
            PH_PARAM: begin
                stat_o[STB_RQM]  = 1'b1;
                stat_o[STB_BUSY] = 1'b1;
            end
            PH_EXEC: stat_o[STB_BUSY] = 1'b1;
            default: begin
                stat_o[STB_RQM]  = 1'b1;
                stat_o[STB_DIO]  = 1'b1;
                stat_o[STB_BUSY] = 1'b1;
            end
        endcase
    end

    assign res_rdata = seq_q.idx ? seq_q.res1 : seq_q.res0;
    assign irq_o     = seq_q.pend;

    // R7
    param_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_PARAM) |-> !irq_o);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(seek_done));

    // R5
    cyl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.pcn <= CYL_W'(MAX_CYL));

    // R3
    exec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_EXEC && cmd_wr && !seek_done) |=> $stable(seq_q.pcn));

    // R6
    exec_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_EXEC) |-> tmr_busy);

    // R11
    result_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_RESULT && res_rd && (!seq_q.two || seq_q.idx)) |=> (stat_o == 8'h80));

    // R8
    sense_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_IDLE && cmd_wr && cmd_wdata == OPC_SENSE) |=> !irq_o);

endmodule

// File: tb/fdc_cmd_seq_bench.sv
`timescale 1ns/1ps
module fdc_cmd_seq_bench;

    localparam int SEEK   = 12;
    localparam int MAXC   = 79;
    localparam int WD_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       res_rd = 1'b0;
    logic [7:0] res_rdata;
    logic [7:0] stat_o;
    logic       irq_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    fdc_cmd_seq #(
        .CYL_W       (8),
        .MAX_CYL     (MAXC),
        .SEEK_CYCLES (SEEK)
    ) u_fdc_cmd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .res_rd    (res_rd),
        .res_rdata (res_rdata),
        .stat_o    (stat_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compares each result byte as the host consumes it
    always @(negedge clk) begin
        if (res_rd && stat_o[7] && stat_o[6]) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected result byte", res_rdata, 8'hxx);
            end else begin
                check(tag_q.pop_front(), res_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic expect_byte(input string tag, input logic [7:0] b);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(posedge clk);
        #1 cmd_wr = 1'b1;
        cmd_wdata = b;
        @(posedge clk);
        #1 cmd_wr = 1'b0;
    endtask

    task automatic rd_byte();
        @(posedge clk);
        #1 res_rd = 1'b1;
        @(posedge clk);
        #1 res_rd = 1'b0;
    endtask

    // Seek with timing checks; returns 1 ns after the completion edge
    task automatic seek(input logic [7:0] op, input logic [7:0] sel, input logic [7:0] arg,
                        input bit poke_exec);
        int t0;
        wr_byte(op);
        check("R7 irq low after seek opcode", {7'b0, irq_o}, 8'h00);
        check("R2 status awaiting params", stat_o, 8'h90);
        wr_byte(sel);
        check("R7 irq low during params", {7'b0, irq_o}, 8'h00);
        wr_byte(arg);
        t0 = cyc;
        check("R2 status in execution", stat_o, 8'h10);
        if (poke_exec) begin
            wr_byte(8'h08);
            check("R3 write in execution ignored", stat_o, 8'h10);
        end
        while (cyc < t0 + SEEK - 1) begin
            @(posedge clk);
            #1;
        end
        check("R6 irq still low one cycle early", {7'b0, irq_o}, 8'h00);
        check("R6 still executing one cycle early", stat_o, 8'h10);
        @(posedge clk);
        #1;
        check("R6 irq high at completion", {7'b0, irq_o}, 8'h01);
        check("R6 idle status at completion", stat_o, 8'h80);
    endtask

    task automatic sense_pending(input logic [7:0] st0, input logic [7:0] cyl, input string tag);
        expect_byte({tag, " ST0"}, st0);
        expect_byte({tag, " cylinder"}, cyl);
        wr_byte(8'h08);
        check("R8 irq cleared after sense", {7'b0, irq_o}, 8'h00);
        check("R2 result status", stat_o, 8'hD0);
        rd_byte();
        rd_byte();
        check("R11 idle after last result", stat_o, 8'h80);
    endtask

    task automatic single_byte(input logic [7:0] op, input string tag);
        expect_byte(tag, 8'h80);
        wr_byte(op);
        check("R2 result status single", stat_o, 8'hD0);
        rd_byte();
        check("R11 idle after single result", stat_o, 8'h80);
    endtask

    initial begin
        #(WD_CYC * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1
        check("R1 reset status", stat_o, 8'h80);
        check("R1 reset irq", {7'b0, irq_o}, 8'h00);

        // R9 sense with nothing pending
        single_byte(8'h08, "R9 sense without pending");

        // R4 absolute seek, head 1 drive 1, with a write poked in execution (R3)
        seek(8'h0F, 8'h05, 8'd40, 1'b1);
        sense_pending(8'h25, 8'd40, "R8 after abs seek");

        // R5 inward clamps at MAXC
        seek(8'hCF, 8'h00, 8'd50, 1'b0);
        sense_pending(8'h20, 8'd79, "R5 inward clamp");

        // R5 outward by 9
        seek(8'h8F, 8'h02, 8'd9, 1'b0);
        sense_pending(8'h22, 8'd70, "R5 outward step");

        // R5 outward past zero clamps
        seek(8'h8F, 8'h00, 8'd200, 1'b0);
        sense_pending(8'h20, 8'd0, "R5 outward clamp");

        // R4 absolute beyond limit
        seek(8'h0F, 8'h04, 8'd200, 1'b0);
        sense_pending(8'h24, 8'd79, "R4 abs clamp");

        // R10 bad opcode with interrupt pending
        seek(8'h0F, 8'h01, 8'd10, 1'b0);
        single_byte(8'h4A, "R10 unknown opcode");
        check("R10 irq kept", {7'b0, irq_o}, 8'h01);

        // R3 write during result phase ignored
        expect_byte("R3 ST0 after ignored write", 8'h21);
        expect_byte("R3 cylinder after ignored write", 8'd10);
        wr_byte(8'h08);
        wr_byte(8'h0F);
        check("R3 still result phase", stat_o, 8'hD0);
        rd_byte();
        rd_byte();
        check("R11 idle after reads", stat_o, 8'h80);

        // R11 read outside result phase ignored
        rd_byte();
        check("R11 idle read ignored", stat_o, 8'h80);
        single_byte(8'h08, "R9 sense after cleared");

        // R7 new seek opcode clears pending interrupt
        seek(8'h0F, 8'h00, 8'd3, 1'b0);
        wr_byte(8'h0F);
        check("R7 seek opcode clears irq", {7'b0, irq_o}, 8'h00);
        wr_byte(8'h00);
        wr_byte(8'd5);
        repeat (SEEK + 2) @(posedge clk);
        #1;
        sense_pending(8'h20, 8'd5, "R4 second abs seek");

        check("R8 scoreboard drained", 8'(exp_q.size()), 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule